// File: doc/BRIEF.md
# MDIO Management Master

This block runs single register transactions on a two-wire PHY management bus. A request carries a direction (read or write), a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The master builds the serial frame, generates the management clock from the system clock, and drives the data line. For reads it releases the data line and collects the reply from the PHY.

The data line is split into an output value, an output enable and an input, so the pad logic outside can form the open or tri-state pin. A request is taken only while the block is idle. Every transaction ends with a single-cycle completion pulse. Read data appears together with that pulse and stays unchanged until the next read completes. Between transactions the management clock rests low, and the data line is driven high.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and between transactions, `mdc` is 0, `mdio_oe` is 1, `mdio_o` is 1, and `busy` is 0. Directly after reset, `done` is 0 and `rd_data` is 0.
- R2: While a transaction runs, `mdc` stays low for HALF_CYC system cycles, then high for HALF_CYC cycles, and repeats. The default HALF_CYC of 12 gives about 2.08 MHz from a 50 MHz clock. Each bit period starts with the low half.
- R3: The first 32 bit periods of every transaction drive `mdio_o` = 1 with `mdio_oe` = 1.
- R4: A write drives 64 bit periods, each bit MSB first: 32 preamble ones, start `01`, opcode `01`, the PHY address, the register address, turnaround `10`, and then the 16 data bits. `mdio_oe` is 1 throughout.
- R5: A read drives the preamble, start `01`, opcode `10`, the PHY address and the register address, which is 46 bit periods. `mdio_oe` is then 0 for the remaining 18 bit periods (indices 46 to 63).
- R6: In a read, `mdio_i` is sampled on the system edge where `mdc` rises, in bit periods 48 to 63. The first sample becomes `rd_data[15]` and the last becomes `rd_data[0]`. The result appears on `rd_data` in the cycle where `done` is 1.
- R7: `mdio_o` changes only on the edge where `mdc` falls. It is therefore stable while `mdc` is high.
- R8: A transaction lasts 64 bit periods. `busy` is 1 for exactly 128*HALF_CYC cycles after the request is accepted. `done` is 1 for one cycle, which is the first cycle with `busy` back at 0.
- R9: `cmd_valid` while `busy` is 1 is ignored. The running frame, its length and the single `done` pulse are unaffected.
- R10: `rd_data` changes only in a cycle where `done` is 1 after a read. A write leaves it holding the last read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Request strobe, taken when `busy` is 0 |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | 16 | Data from the last completed read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
A bit counter or shift register out of step shows at the ports within one bit period of 2*HALF_CYC cycles. It appears as a misplaced field bit, an early or late release of `mdio_oe`, or a data line that moves while `mdc` is high. A fault in the clock divider breaks the half-period length at the very next `mdc` edge. Faults in the end-of-frame logic show up as a wrong `busy` length or a missing or doubled `done` pulse. Faults in the read capture show as wrong `rd_data` in the completion cycle, or as `rd_data` moving at some other time.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_W      = 5;
    localparam int REG_W      = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 4;
    localparam int TA_BITS    = 2;
    localparam int FRAME_BITS = PRE_BITS + HDR_BITS + PHY_W + REG_W + TA_BITS + DATA_W;
    localparam int REL_IDX    = PRE_BITS + HDR_BITS + PHY_W + REG_W;
    localparam int DATA_IDX   = REL_IDX + TA_BITS;
    localparam int BITCNT_W   = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10
    } mdio_opc_e;

    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] WR_TA    = 2'b10;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } mdio_state_e;

    typedef struct packed {
        logic              is_read;
        logic [PHY_W-1:0]  phy;
        logic [REG_W-1:0]  regad;
        logic [DATA_W-1:0] wdata;
    } mdio_cmd_t;

    // Serial image of a whole transaction, first bit in the MSB.
    // In a read, the bits after the register field are never driven; they are
    // filled with ones so that the line returns to idle level cleanly.
    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
        logic [FRAME_BITS-1:0] f;
        mdio_opc_e             opc;
        opc = c.is_read ? OPC_READ : OPC_WRITE;
        if (c.is_read)
            f = {{PRE_BITS{1'b1}}, SOF_CODE, opc, c.phy, c.regad,
                 {(TA_BITS + DATA_W){1'b1}}};
        else
            f = {{PRE_BITS{1'b1}}, SOF_CODE, opc, c.phy, c.regad,
                 WR_TA, c.wdata};
        return f;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_CYC = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CNT_W = $clog2(HALF_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;
    logic             wrap;

    assign wrap     = run && (cnt_q == CNT_LAST);
    assign rise_evt = wrap && !phase_q;
    assign fall_evt = wrap && phase_q;
    assign mdc      = phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (wrap) begin
            cnt_q   <= '0;
            phase_q <= !phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  shift,
    input  logic                  release_line,
    input  logic                  reclaim_line,
    output logic                  mdio_o,
    output logic                  mdio_oe
);
    logic [FRAME_BITS-1:0] sr_q;
    logic                  oe_q;

    assign mdio_o  = sr_q[FRAME_BITS-1];
    assign mdio_oe = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '1;
        end else if (load) begin
            sr_q <= frame;
        end else if (shift) begin
            sr_q <= {sr_q[FRAME_BITS-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || reclaim_line || load) begin
            oe_q <= 1'b1;
        end else if (release_line) begin
            oe_q <= 1'b0;
        end
    end
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic              din,
    input  logic              commit,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] out_q;

    assign rd_data = out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (sample) begin
            acc_q <= {acc_q[DATA_W-2:0], din};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (commit) begin
            out_q <= acc_q;
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_CYC = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [PHY_W-1:0]  cmd_phy,
    input  logic [REG_W-1:0]  cmd_reg,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam logic [BITCNT_W-1:0] LAST_BIT  = BITCNT_W'(FRAME_BITS - 1);
    localparam logic [BITCNT_W-1:0] PRE_REL   = BITCNT_W'(REL_IDX - 1);
    localparam logic [BITCNT_W-1:0] FIRST_DAT = BITCNT_W'(DATA_IDX);

    mdio_state_e         state_q;
    logic [BITCNT_W-1:0] bit_q;
    logic                rd_q;
    logic                done_q;

    mdio_cmd_t           cmd;
    logic                accept;
    logic                run;
    logic                rise_evt;
    logic                fall_evt;
    logic                last;

    assign cmd.is_read = cmd_read;
    assign cmd.phy     = cmd_phy;
    assign cmd.regad   = cmd_reg;
    assign cmd.wdata   = cmd_wdata;

    assign accept = cmd_valid && (state_q == ST_IDLE);
    assign run    = (state_q == ST_XFER);
    assign last   = fall_evt && (bit_q == LAST_BIT);
    assign busy   = run;
    assign done   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            rd_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_XFER;
                        bit_q   <= '0;
                        rd_q    <= cmd_read;
                    end
                end
                ST_XFER: begin
                    if (fall_evt) begin
                        bit_q <= bit_q + 1'b1;
                        if (last) state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    mdio_mdc_gen #(.HALF_CYC(HALF_CYC)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_tx_shift u_tx (
        .clk          (clk),
        .rst          (rst),
        .load         (accept),
        .frame        (build_frame(cmd)),
        .shift        (fall_evt),
        .release_line (fall_evt && rd_q && (bit_q == PRE_REL)),
        .reclaim_line (last),
        .mdio_o       (mdio_o),
        .mdio_oe      (mdio_oe)
    );

    mdio_rx_capture u_rx (
        .clk     (clk),
        .rst     (rst),
        .sample  (rise_evt && rd_q && (bit_q >= FIRST_DAT)),
        .din     (mdio_i),
        .commit  (last && rd_q),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
    import mdio_pkg::*;
#(
    parameter int HALF_CYC = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rd_data,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !mdc) hi_cnt <= '0;
        else             hi_cnt <= hi_cnt + 16'd1;
    end

    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);                                             // R1
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mdio_oe && mdio_o));                              // R1
    AST_HIGH_HALF_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(mdc) |-> (hi_cnt == 16'(HALF_CYC)));                   // R2
    AST_RELEASE_IN_XFER: assert property (@(posedge clk) disable iff (rst)
        !mdio_oe |-> busy);                                          // R5
    AST_OUT_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_o) |-> $fell(mdc));                            // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                             // R8
    AST_DONE_ENDS_XFER: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));                            // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rd_data));                                 // R10
endmodule

bind mdio_master mdio_master_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int HALF = 12;
    localparam int NBIT = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_read = 1'b0;
    logic [4:0]  cmd_phy = '0;
    logic [4:0]  cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    mdio_master #(.HALF_CYC(HALF)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
        .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #10 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;

    // PHY model and port monitor state
    logic [15:0] phy_data = '0;
    logic        cap_o  [NBIT];
    logic        cap_oe [NBIT];
    int rise_n, fall_n, run_len, half_bad, r7_bad, done_cnt, busy_cyc;
    logic prev_mdc = 1'b0, prev_o = 1'b1, prev_busy = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (busy && !prev_busy) begin
                run_len = 1;
            end else if (busy) begin
                if (mdc == prev_mdc) run_len++;
                else begin
                    if (run_len != HALF) half_bad++;
                    run_len = 1;
                end
            end
            if (busy && mdc && !prev_mdc) begin
                if (rise_n < NBIT) begin
                    cap_o[rise_n]  = mdio_o;
                    cap_oe[rise_n] = mdio_oe;
                end
                rise_n++;
            end
            if (busy && !mdc && prev_mdc) begin
                fall_n++;
                mdio_i = (fall_n >= 48 && fall_n <= 63) ? phy_data[63 - fall_n] : 1'b1;
            end
            if (!busy) mdio_i = 1'b1;
            if (mdio_o !== prev_o && !(prev_mdc && !mdc)) r7_bad++;
            if (busy) busy_cyc++;
            if (done) done_cnt++;
        end
        prev_mdc  = mdc;
        prev_o    = mdio_o;
        prev_busy = busy;
    end

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] pa,
                                              input logic [4:0] ra, input logic [15:0] wd);
        if (rd) return {32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra, 18'h0};
        return {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, wd};
    endfunction

    logic [15:0] last_read = '0;

    task automatic xact(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] wd, input logic [15:0] pd, input bit intrude);
        logic [63:0] ef;
        int drv, bad_hdr, bad_pre, bad_rel, guard;
        phy_data = pd;
        rise_n = 0; fall_n = 0; half_bad = 0; r7_bad = 0; done_cnt = 0; busy_cyc = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_read = rd; cmd_phy = pa; cmd_reg = ra; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_read = ~rd; cmd_phy = ~pa; cmd_reg = ~ra; cmd_wdata = ~wd;
        if (intrude) begin
            repeat (400) @(negedge clk);
            cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        guard = 0;
        while (!done && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        ef  = exp_frame(rd, pa, ra, wd);
        drv = rd ? 46 : 64;
        bad_pre = 0; bad_hdr = 0; bad_rel = 0;
        for (int i = 0; i < 32; i++) if (cap_o[i] !== 1'b1 || cap_oe[i] !== 1'b1) bad_pre++;
        for (int i = 32; i < drv; i++) if (cap_o[i] !== ef[63 - i] || cap_oe[i] !== 1'b1) bad_hdr++;
        for (int i = 46; i < 64; i++) if (rd && cap_oe[i] !== 1'b0) bad_rel++;
        chk(bad_pre == 0, "R3", "preamble bit errors", bad_pre, 0);
        chk(bad_hdr == 0, rd ? "R5" : "R4", "frame field bit errors", bad_hdr, 0);
        if (rd) chk(bad_rel == 0, "R5", "bits not released", bad_rel, 0);
        if (rd) begin
            chk(rd_data == pd, "R6", "read data", rd_data, pd);
            last_read = pd;
        end else begin
            chk(rd_data == last_read, "R10", "read data after write", rd_data, last_read);
        end
        chk(busy_cyc == NBIT * 2 * HALF, "R8", "busy cycles", busy_cyc, NBIT * 2 * HALF);
        chk(done_cnt == 1 && rise_n == NBIT, "R8", "done pulses*100+mdc rises",
            done_cnt * 100 + rise_n, 100 + NBIT);
        chk(half_bad == 0, "R2", "bad mdc half periods", half_bad, 0);
        chk(r7_bad == 0, "R7", "mdio_o moves off mdc fall", r7_bad, 0);
        if (intrude)
            chk(done_cnt == 1 && bad_hdr == 0, "R9", "busy-time request effect",
                bad_hdr + done_cnt, 1);
        chk(!mdc && mdio_o && mdio_oe && !busy, "R1", "idle mdc,o,oe,busy",
            {mdc, mdio_o, mdio_oe, busy}, 4'b0110);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "ALL", "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mdc && mdio_o && mdio_oe && !busy && !done, "R1", "reset mdc,o,oe,busy,done",
            {mdc, mdio_o, mdio_oe, busy, done}, 5'b01100);
        chk(rd_data == 16'h0, "R1", "reset rd_data", rd_data, 0);
        // directed corners
        xact(1'b0, 5'd0,  5'd0,  16'h0000, 16'h0000, 1'b0);
        xact(1'b0, 5'd31, 5'd31, 16'hFFFF, 16'h0000, 1'b0);
        xact(1'b1, 5'd1,  5'd1,  16'h0000, 16'hFFFF, 1'b0);
        xact(1'b1, 5'd31, 5'd0,  16'h0000, 16'h0000, 1'b0);
        xact(1'b1, 5'd10, 5'd21, 16'h0000, 16'hA5C3, 1'b1);
        xact(1'b0, 5'd5,  5'd4,  16'h8001, 16'h1234, 1'b1);
        xact(1'b0, 5'd17, 5'd3,  16'h5A5A, 16'h0F0F, 1'b0);
        // random mix
        for (int k = 0; k < 12; k++) begin
            xact(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                 16'($urandom), 1'($urandom_range(0, 3) == 0));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule